// File: doc/BRIEF.md
# Head Stepper Phase Sequencer with Automatic Recalibration

This block drives the four windings of a head-positioning stepper motor through an eight-state half-step sequence. A rising edge on the step request input moves the sequence one state forward or back, as chosen by the direction input. Every move opens a step-enable window of fixed length. Every move also restarts a settle timer. Seek complete is raised only after that timer has run out.

Reset loads the track-zero phase and arms a recalibration request. When the drive is ready and the heads are not at track zero, the block steps outward by itself. The once-per-revolution index pulse serves as the step clock. The block stops when the track-zero phase and the track-zero sensor agree, then waits out the settle time before it reports seek complete. Host steps are only accepted once this recalibration has finished.

Top module: `head_step_sequencer`

## Requirements
- R1: `phase_n_o` is active low with bit 0 = A1, bit 1 = A2, bit 2 = B1, bit 3 = B2. Phase states 0 to 7 energise the windings in this order: A1, A1+B1, B1, A2+B1, A2, A2+B2, B2, A1+B2. Single-winding states drive exactly one line low and two-winding states drive exactly two lines low.
- R2: While `rst` is high, and after its release until the first step, the block holds phase state 3 (`phase_n_o` = 4'b1001) with `step_win_o` low. In that period `seek_done_o` stays low unless the heads are at track zero.
- R3: With no recalibration pending, each rising edge of `step_i` moves the phase one state. The move is +1 when `dir_i` = 1 and -1 when `dir_i` = 0, wrapping between 7 and 0. The new phase appears on the clock edge that samples the rising edge.
- R4: Every phase move drives `step_win_o` high for exactly WIN_CYC cycles, starting at the edge of the move. A further move restarts the full width.
- R5: Recalibration moves only while `ready_i` is high and the heads are not at track zero. With `ready_i` low, index pulses leave the phase unchanged.
- R6: During recalibration, each rising edge of `index_i` that arrives while `step_win_o` is low moves the phase one state backward (outward), whatever `dir_i` is. Index edges that arrive while `step_win_o` is high are ignored.
- R7: Recalibration ends once the phase is 3 and `trk0_i` is high. After that, index pulses have no effect. While recalibration is pending, `step_i` edges have no effect.
- R8: `seek_done_o` goes low at the edge of any phase move. It returns high WIN-independent, SETTLE_CYC+1 cycles after the last move, provided no recalibration is pending. Each move restarts this interval.
- R9: When `trk0_i` is high at reset release, `seek_done_o` rises on the second clock edge after release, without any step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready_i | input | 1 | Spindle at speed; enables recalibration |
| index_i | input | 1 | Once-per-revolution index pulse |
| step_i | input | 1 | Host step request, acted on at its rising edge |
| dir_i | input | 1 | Host step direction, 1 = forward (+1) |
| trk0_i | input | 1 | Track-zero sensor, high at the outer track |
| phase_n_o | output | 4 | Active-low winding drives {B2,B1,A2,A1} |
| step_win_o | output | 1 | Step-enable window after each move |
| seek_done_o | output | 1 | Seek complete after settle |

## Verification
Host steps are tried in runs that cross the wrap in both directions. These runs show that the counter is circular and that the direction sense is right, and each state's pattern is compared against the winding table. Recalibration is exercised four ways:
- with ready low, to show that ready gates it;
- with back-to-back index pulses, where the second falls inside the window, to show that index pulses within the window are ignored;
- with the track-zero sensor still low on the first arrival at phase 3, to show that only the phase-and-sensor match ends it;
- with a host step issued during recalibration, to show that host steps are blocked.

Paired moves a few cycles apart separate timers that restart on every move from timers that run only from the first move. This applies to both the window and the settle interval.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
  localparam int PH_W      = 3;
  localparam int WIND_W    = 4;
  localparam logic [PH_W-1:0] TZ_PHASE = 3'd3;

  // Active-high winding set {B2,B1,A2,A1} for each half-step state.
  function automatic logic [WIND_W-1:0] ph_decode(input logic [PH_W-1:0] idx);
    logic [WIND_W-1:0] w;
    case (idx)
      3'd0:    w = 4'b0001;
      3'd1:    w = 4'b0101;
      3'd2:    w = 4'b0100;
      3'd3:    w = 4'b0110;
      3'd4:    w = 4'b0010;
      3'd5:    w = 4'b1010;
      3'd6:    w = 4'b1000;
      default: w = 4'b1001;
    endcase
    return w;
  endfunction

  // Inverse mapping, used by the checker.
  function automatic logic [PH_W-1:0] ph_encode(input logic [WIND_W-1:0] w);
    logic [PH_W-1:0] idx;
    case (w)
      4'b0001: idx = 3'd0;
      4'b0101: idx = 3'd1;
      4'b0100: idx = 3'd2;
      4'b0110: idx = 3'd3;
      4'b0010: idx = 3'd4;
      4'b1010: idx = 3'd5;
      4'b1000: idx = 3'd6;
      default: idx = 3'd7;
    endcase
    return idx;
  endfunction
endpackage

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] START = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  // busy is high for exactly CYCLES edges after the load edge; a load restarts it.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= START;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/phase_counter.sv
module phase_counter
  import stepper_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              up,
  output logic [PH_W-1:0]   phase_idx,
  output logic [WIND_W-1:0] phase_n
);
  logic [PH_W-1:0] nxt;

  always_comb begin
    nxt = phase_idx;
    if (adv) nxt = up ? phase_idx + 1'b1 : phase_idx - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_idx <= TZ_PHASE;
      phase_n   <= ~ph_decode(TZ_PHASE);
    end else begin
      phase_idx <= nxt;
      phase_n   <= ~ph_decode(nxt);
    end
  end
endmodule

// File: rtl/step_arbiter.sv
module step_arbiter
  import stepper_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            step_i,
  input  logic            index_i,
  input  logic            dir_i,
  input  logic            ready_i,
  input  logic            trk0_i,
  input  logic [PH_W-1:0] phase_idx,
  input  logic            win_busy,
  output logic            adv,
  output logic            adv_up,
  output logic            recal_pend
);
  logic step_q, idx_q, recal_q;
  logic step_rise, idx_rise, at_zero, recal_go;

  assign step_rise = step_i & ~step_q;
  assign idx_rise  = index_i & ~idx_q;
  assign at_zero   = trk0_i & (phase_idx == TZ_PHASE);
  assign recal_go  = recal_q & ready_i & ~at_zero;

  always_comb begin
    if (recal_q) begin
      adv    = recal_go & idx_rise & ~win_busy;
      adv_up = 1'b0;
    end else begin
      adv    = step_rise;
      adv_up = dir_i;
    end
  end

  // Edge registers reset high so a line held high at release needs a fresh rise.
  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= 1'b1;
      idx_q   <= 1'b1;
      recal_q <= 1'b1;
    end else begin
      step_q <= step_i;
      idx_q  <= index_i;
      if (recal_q && at_zero) recal_q <= 1'b0;
    end
  end

  assign recal_pend = recal_q;
endmodule

// File: rtl/head_step_sequencer.sv
module head_step_sequencer
  import stepper_pkg::*;
#(
  parameter int WIN_CYC    = 1400,
  parameter int SETTLE_CYC = 1800000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ready_i,
  input  logic              index_i,
  input  logic              step_i,
  input  logic              dir_i,
  input  logic              trk0_i,
  output logic [WIND_W-1:0] phase_n_o,
  output logic              step_win_o,
  output logic              seek_done_o
);
  logic [PH_W-1:0] phase_idx;
  logic adv, adv_up, recal_pend, settle_busy;

  step_arbiter u_arb (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step_i),
    .index_i    (index_i),
    .dir_i      (dir_i),
    .ready_i    (ready_i),
    .trk0_i     (trk0_i),
    .phase_idx  (phase_idx),
    .win_busy   (step_win_o),
    .adv        (adv),
    .adv_up     (adv_up),
    .recal_pend (recal_pend)
  );

  phase_counter u_phase (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .up        (adv_up),
    .phase_idx (phase_idx),
    .phase_n   (phase_n_o)
  );

  hold_timer #(.CYCLES(WIN_CYC)) u_win (
    .clk  (clk),
    .rst  (rst),
    .load (adv),
    .busy (step_win_o)
  );

  hold_timer #(.CYCLES(SETTLE_CYC)) u_settle (
    .clk  (clk),
    .rst  (rst),
    .load (adv),
    .busy (settle_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) seek_done_o <= 1'b0;
    else     seek_done_o <= ~settle_busy & ~recal_pend & ~adv;
  end
endmodule

// File: rtl/stepper_seq_chk.sv
module stepper_seq_chk
  import stepper_pkg::*;
#(
  parameter int WIN_CYC = 1400
) (
  input logic              clk,
  input logic              rst,
  input logic [WIND_W-1:0] phase_n_o,
  input logic              step_win_o,
  input logic              seek_done_o
);
  logic [WIND_W-1:0] prev_q;
  int unsigned       cnt_q;
  int unsigned       age;
  logic [PH_W-1:0]   cur_idx, prv_idx;

  assign cur_idx = ph_encode(~phase_n_o);
  assign prv_idx = ph_encode(~prev_q);
  assign age     = (phase_n_o != prev_q) ? 1 : cnt_q + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= phase_n_o;
      cnt_q  <= 0;
    end else begin
      prev_q <= phase_n_o;
      cnt_q  <= step_win_o ? age : 0;
    end
  end

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    ($countones(~phase_n_o) inside {1, 2}) && (ph_decode(cur_idx) == ~phase_n_o)); // R1

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (phase_n_o == 4'b1001) && !step_win_o); // R2

  AST_PHASE_ADJ: assert property (@(posedge clk) disable iff (rst)
    (phase_n_o != prev_q) |-> ((cur_idx == prv_idx + 3'd1) || (cur_idx == prv_idx - 3'd1))); // R3

  AST_WIN_ON_MOVE: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase_n_o) |-> step_win_o); // R4

  AST_WIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    step_win_o |-> (age <= WIN_CYC)); // R4

  AST_SEEK_DROP: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase_n_o) |-> !seek_done_o); // R8
endmodule

bind head_step_sequencer stepper_seq_chk #(.WIN_CYC(WIN_CYC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .phase_n_o   (phase_n_o),
  .step_win_o  (step_win_o),
  .seek_done_o (seek_done_o)
);

// File: tb/tb_head_step_sequencer.sv
module tb_head_step_sequencer;
  localparam int W = 8;
  localparam int S = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ready_i = 1'b0, index_i = 1'b0, step_i = 1'b0, dir_i = 1'b0, trk0_i = 1'b0;
  logic [3:0] phase_n_o;
  logic step_win_o, seek_done_o;
  int checks = 0, errors = 0;
  int exp_ph = 3;
  bit done = 1'b0;

  always #5 clk = ~clk;

  head_step_sequencer #(.WIN_CYC(W), .SETTLE_CYC(S)) dut (
    .clk(clk), .rst(rst), .ready_i(ready_i), .index_i(index_i), .step_i(step_i),
    .dir_i(dir_i), .trk0_i(trk0_i), .phase_n_o(phase_n_o), .step_win_o(step_win_o),
    .seek_done_o(seek_done_o)
  );

  // Active-low pattern {B2,B1,A2,A1} per state, from the winding table.
  function automatic logic [3:0] pat(input int idx);
    case (idx & 7)
      0: return ~4'b0001;
      1: return ~4'b0101;
      2: return ~4'b0100;
      3: return ~4'b0110;
      4: return ~4'b0010;
      5: return ~4'b1010;
      6: return ~4'b1000;
      default: return ~4'b1001;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_idx;
    @(negedge clk) index_i = 1'b1;
    @(negedge clk) index_i = 1'b0;
  endtask

  task automatic pulse_step;
    @(negedge clk) step_i = 1'b1;
    @(negedge clk) step_i = 1'b0;
  endtask

  task automatic do_reset(input logic tz);
    trk0_i = tz;
    @(negedge clk) rst = 1'b1;
    negs(3);
    chk("R2 phase in reset", phase_n_o, 4'b1001);
    chk("R2 window in reset", step_win_o, 1'b0);
    chk("R2 seek in reset", seek_done_o, 1'b0);
    rst = 1'b0;
    exp_ph = 3;
  endtask

  task automatic t_reset_away;
    ready_i = 1'b0;
    do_reset(1'b0);
    negs(30);
    chk("R2 seek low away from zero", seek_done_o, 1'b0);
    chk("R2 phase held", phase_n_o, 4'b1001);
  endtask

  task automatic t_not_ready;
    pulse_idx();
    negs(W + 2);
    chk("R5 index ignored when not ready", phase_n_o, pat(exp_ph));
  endtask

  task automatic t_recal;
    int steps = 0;
    ready_i = 1'b1;
    dir_i = 1'b1;
    pulse_step();
    negs(W + 2);
    chk("R7 host step ignored during recal", phase_n_o, pat(exp_ph));
    pulse_idx();
    exp_ph = (exp_ph - 1) & 7;
    chk("R6 index steps outward", phase_n_o, pat(exp_ph));
    chk("R4 window opens", step_win_o, 1'b1);
    negs(W - 1);
    chk("R4 window last cycle", step_win_o, 1'b1);
    negs(1);
    chk("R4 window closed", step_win_o, 1'b0);
    pulse_idx();
    exp_ph = (exp_ph - 1) & 7;
    negs(1);
    pulse_idx();
    chk("R6 index inside window ignored", phase_n_o, pat(exp_ph));
    negs(W + 1);
    while (steps < 24) begin
      pulse_idx();
      exp_ph = (exp_ph - 1) & 7;
      steps++;
      chk("R1 R6 recal phase", phase_n_o, pat(exp_ph));
      if (exp_ph == 7 && steps > 8) trk0_i = 1'b1;
      if (exp_ph == 3 && trk0_i) break;
      negs(W + 1);
    end
    chk("R7 recal reached zero phase", phase_n_o, 4'b1001);
    chk("R8 seek low after last step", seek_done_o, 1'b0);
    negs(S);
    chk("R8 seek still settling", seek_done_o, 1'b0);
    negs(1);
    chk("R8 seek after settle", seek_done_o, 1'b1);
    pulse_idx();
    negs(W + 2);
    chk("R7 index ignored after recal", phase_n_o, 4'b1001);
    chk("R7 seek stays high", seek_done_o, 1'b1);
  endtask

  task automatic t_ext_steps;
    dir_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      pulse_step();
      exp_ph = (exp_ph + 1) & 7;
      chk("R1 R3 forward step", phase_n_o, pat(exp_ph));
    end
    chk("R3 forward wrap to 0", phase_n_o, pat(0));
    dir_i = 1'b0;
    pulse_step();
    exp_ph = (exp_ph - 1) & 7;
    chk("R3 backward wrap to 7", phase_n_o, pat(7));
    negs(2);
    chk("R3 no step without edge", phase_n_o, pat(7));
  endtask

  task automatic t_restart;
    negs(W + 2);
    pulse_step();
    exp_ph = (exp_ph - 1) & 7;
    negs(2);
    pulse_step();
    exp_ph = (exp_ph - 1) & 7;
    chk("R3 second backward step", phase_n_o, pat(exp_ph));
    negs(W - 1);
    chk("R4 window restarted", step_win_o, 1'b1);
    negs(1);
    chk("R4 restarted window closes", step_win_o, 1'b0);
    negs(S + 5);
    chk("R8 settled before restart test", seek_done_o, 1'b1);
    pulse_step();
    chk("R8 seek drops on step", seek_done_o, 1'b0);
    negs(30);
    pulse_step();
    negs(S);
    chk("R8 settle restarted", seek_done_o, 1'b0);
    negs(1);
    chk("R8 settle ends after last step", seek_done_o, 1'b1);
  endtask

  task automatic t_reset_zero;
    do_reset(1'b1);
    negs(1);
    chk("R9 seek not yet", seek_done_o, 1'b0);
    negs(2);
    chk("R9 seek at zero after reset", seek_done_o, 1'b1);
    chk("R2 phase after reset", phase_n_o, 4'b1001);
  endtask

  initial begin
    t_reset_away();
    t_not_ready();
    t_recal();
    t_ext_steps();
    t_restart();
    t_reset_zero();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule